// File: doc/BRIEF.md
# Frameless Serial Bus Byte Monitor

This block listens passively to a three-wire serial bus: one clock line that idles high, a master data line and a slave data line. There is no chip select, so byte boundaries are recovered from the clock line alone. Each byte is eight clock cycles, with data taken on rising clock edges and most significant bit first. After the eighth rising edge the clock stays high for a long stretch. The slave then holds the clock low for an acknowledge/busy interval of variable length. The monitor tells this acknowledge low apart from an ordinary bit low by the length of the high interval before it. That interval is compared with a programmable threshold counted in system clock cycles.

All three lines are oversampled by the fast system clock. Each passes through a two-stage synchroniser and a stability filter that rejects short spikes. When the acknowledge low ends, the monitor presents both captured bytes and the acknowledge length in system cycles, with a one-cycle valid strobe. Bursts of clock activity that do not fit the eight-bits-then-acknowledge pattern raise a one-cycle framing error pulse and restart bit counting.

Top module: `sniff_byte_mon`

## Requirements
- R1: After reset, `mst_byte`, `slv_byte` and `ack_len` are zero, and `byte_vld` and `frame_err` are low.
- R2: The master byte is built from `bus_mosi` sampled at eight successive filtered rising edges of `bus_clk`, first sample in bit 7.
- R3: The slave byte is built in the same way from `bus_miso`, first sample in bit 7.
- R4: `byte_vld` pulses high for exactly one cycle when the acknowledge low ends. An acknowledge low is the first falling clock edge after exactly eight bits, when the clock was high for more than `idle_thresh` system cycles before that edge.
- R5: `ack_len` equals the number of system cycles for which `bus_clk` was held low during the acknowledge, for lows of at least `FILT_LEN` cycles.
- R6: `ack_len` saturates at 2^ACK_W-1 when the acknowledge low is longer than that.
- R7: If the clock stays high for more than `idle_thresh` cycles after one to seven bits, `frame_err` pulses once, the partial byte is dropped with no `byte_vld`, and the next byte is captured from its first bit.
- R8: A falling edge after eight bits, with a high interval of at most `idle_thresh` cycles, pulses `frame_err`. That edge begins the first bit of a new byte.
- R9: A level on any bus line that lasts fewer than `FILT_LEN` system cycles has no effect on the outputs.
- R10: A clock that idles high with no bits pending never raises `frame_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Observed bus clock line (idles high) |
| bus_mosi | input | 1 | Observed master-to-slave data line |
| bus_miso | input | 1 | Observed slave-to-master data line |
| idle_thresh | input | IDLE_W | High-interval length, in system cycles, that must be exceeded before an acknowledge low |
| mst_byte | output | 8 | Last captured master byte |
| slv_byte | output | 8 | Last captured slave byte |
| byte_vld | output | 1 | One-cycle strobe: a new byte pair and acknowledge length are available |
| ack_len | output | ACK_W | Acknowledge low length in system cycles, saturating |
| frame_err | output | 1 | One-cycle strobe on a malformed frame |

## Verification
The capture path is driven with complementary and asymmetric byte pairs (A5/3C, 00/FF, 81/7E, 5A/C3), which separate a bit-order error from a lane swap between the two data lines. Acknowledge lows of 4, 7, 20 and 300 cycles probe the exact-length count at the filter boundary and the saturation point. A high interval of exactly one cycle over the threshold checks the comparison edge. Malformed traffic covers a five-bit fragment followed by a long idle and eight bits followed at once by a new byte. The second tells the restart-from-this-edge rule apart from a simple discard. Short spikes on the data line inside a bit and on the clock during idle confirm that the filter suppresses them.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    // Bit positions of the three observed lines inside the raw line vector
    localparam int LN_CLK   = 0;
    localparam int LN_MOSI  = 1;
    localparam int LN_MISO  = 2;
    localparam int NUM_LINES = 3;

    localparam int BYTE_BITS = 8;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_ACK  = 1'b1
    } phase_e;

endpackage

// File: rtl/sniff_line_filter.sv
module sniff_line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 4,
    parameter logic RESET_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   filt_d, filt_q;
    logic [CNT_W-1:0]       cnt_d, cnt_q;
    logic                   smp;

    assign smp = sync_q[SYNC_STAGES-1];

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], din};
        filt_d = filt_q;
        cnt_d  = '0;
        if (smp != filt_q) begin
            if (cnt_q == CNT_LAST) begin
                filt_d = smp;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RESET_VAL}};
            filt_q <= RESET_VAL;
            cnt_q  <= '0;
        end else begin
            sync_q <= sync_d;
            filt_q <= filt_d;
            cnt_q  <= cnt_d;
        end
    end

    assign dout = filt_q;

    // A freshly differing sample must not pass straight through
    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && smp != filt_q) |=> (filt_q == $past(filt_q))); // R9

    // The output only ever takes the value the synchroniser presented
    AST_FILT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> (filt_q == $past(smp))); // R9

endmodule

// File: rtl/sniff_frame_ctrl.sv
module sniff_frame_ctrl
    import sniff_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int ACK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk,
    input  logic              line_mo,
    input  logic              line_mi,
    input  logic [IDLE_W-1:0] idle_thresh,
    output logic [7:0]        mst_byte,
    output logic [7:0]        slv_byte,
    output logic              byte_vld,
    output logic [ACK_W-1:0]  ack_len,
    output logic              frame_err
);

    localparam logic [IDLE_W-1:0] IDLE_MAX = '1;
    localparam logic [ACK_W-1:0]  ACK_MAX  = '1;
    localparam logic [3:0]        FULL_CNT = 4'(BYTE_BITS);

    typedef struct packed {
        logic              clk_prev;
        phase_e            phase;
        logic [3:0]        bit_cnt;
        logic [7:0]        mo_sh;
        logic [7:0]        mi_sh;
        logic [IDLE_W-1:0] idle_cnt;
        logic [ACK_W-1:0]  ack_cnt;
        logic [7:0]        mst;
        logic [7:0]        slv;
        logic              vld;
        logic [ACK_W-1:0]  ack_len;
        logic              err;
    } st_t;

    st_t st_d, st_q;
    logic rise, fall, long_now, long_prev, partial;

    always_comb begin
        st_d          = st_q;
        st_d.vld      = 1'b0;
        st_d.err      = 1'b0;
        st_d.clk_prev = line_clk;

        rise = line_clk & ~st_q.clk_prev;
        fall = ~line_clk & st_q.clk_prev;

        // length of the current high interval, first high cycle counts as 1
        if (line_clk) begin
            if (rise)
                st_d.idle_cnt = IDLE_W'(1);
            else if (st_q.idle_cnt != IDLE_MAX)
                st_d.idle_cnt = st_q.idle_cnt + IDLE_W'(1);
        end else begin
            st_d.idle_cnt = '0;
        end

        long_now  = line_clk && (st_d.idle_cnt > idle_thresh);
        long_prev = st_q.idle_cnt > idle_thresh;
        partial   = (st_q.bit_cnt != 4'd0) && (st_q.bit_cnt < FULL_CNT);

        // acknowledge low length, saturating
        if (st_q.phase == PH_ACK && !line_clk && st_q.ack_cnt != ACK_MAX)
            st_d.ack_cnt = st_q.ack_cnt + ACK_W'(1);

        if (rise) begin
            if (st_q.phase == PH_ACK) begin
                st_d.phase   = PH_DATA;
                st_d.mst     = st_q.mo_sh;
                st_d.slv     = st_q.mi_sh;
                st_d.ack_len = st_q.ack_cnt;
                st_d.vld     = 1'b1;
                st_d.bit_cnt = '0;
            end else begin
                st_d.mo_sh = {st_q.mo_sh[6:0], line_mo};
                st_d.mi_sh = {st_q.mi_sh[6:0], line_mi};
                if (st_q.bit_cnt < FULL_CNT)
                    st_d.bit_cnt = st_q.bit_cnt + 4'd1;
            end
        end else if (fall) begin
            if (st_q.bit_cnt == FULL_CNT) begin
                if (long_prev) begin
                    st_d.phase   = PH_ACK;
                    st_d.ack_cnt = ACK_W'(1);
                end else begin
                    // ninth low without a pause: restart, this low opens bit one
                    st_d.err     = 1'b1;
                    st_d.bit_cnt = '0;
                end
            end
        end else if (long_now && !long_prev && partial) begin
            st_d.err     = 1'b1;
            st_d.bit_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.clk_prev <= 1'b1;
            st_q.phase    <= PH_DATA;
        end else begin
            st_q <= st_d;
        end
    end

    assign mst_byte  = st_q.mst;
    assign slv_byte  = st_q.slv;
    assign byte_vld  = st_q.vld;
    assign ack_len   = st_q.ack_len;
    assign frame_err = st_q.err;

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld); // R4

    AST_VLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> ($past(st_q.phase) == PH_ACK)); // R4

    AST_ACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA && st_q.bit_cnt != FULL_CNT) |=> (st_q.phase == PH_DATA)); // R4

    AST_ACK_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ACK && st_q.ack_cnt == ACK_MAX) |=>
            (st_q.ack_cnt == ACK_MAX || st_q.phase == PH_DATA)); // R6

    AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bit_cnt <= FULL_CNT); // R8

    AST_ERR_NOT_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !byte_vld); // R7

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bit_cnt == 4'd0 && st_q.phase == PH_DATA && line_clk && st_q.clk_prev) |=> !frame_err); // R10

endmodule

// File: rtl/sniff_byte_mon.sv
module sniff_byte_mon
    import sniff_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int IDLE_W      = 16,
    parameter int ACK_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic              bus_mosi,
    input  logic              bus_miso,
    input  logic [IDLE_W-1:0] idle_thresh,
    output logic [7:0]        mst_byte,
    output logic [7:0]        slv_byte,
    output logic              byte_vld,
    output logic [ACK_W-1:0]  ack_len,
    output logic              frame_err
);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;

    always_comb begin
        raw_lines          = '0;
        raw_lines[LN_CLK]  = bus_clk;
        raw_lines[LN_MOSI] = bus_mosi;
        raw_lines[LN_MISO] = bus_miso;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        sniff_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .RESET_VAL   (1'b1)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_lines[g]),
            .dout  (clean_lines[g])
        );
    end

    sniff_frame_ctrl #(
        .IDLE_W (IDLE_W),
        .ACK_W  (ACK_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_clk    (clean_lines[LN_CLK]),
        .line_mo     (clean_lines[LN_MOSI]),
        .line_mi     (clean_lines[LN_MISO]),
        .idle_thresh (idle_thresh),
        .mst_byte    (mst_byte),
        .slv_byte    (slv_byte),
        .byte_vld    (byte_vld),
        .ack_len     (ack_len),
        .frame_err   (frame_err)
    );

endmodule

// File: tb/sim_sniff_byte_mon.sv
`timescale 1ns/1ps
module sim_sniff_byte_mon;

    localparam int IDLE_W = 12;
    localparam int ACK_W  = 8;
    localparam int FLEN   = 4;
    localparam int HALF   = 8;
    localparam int GAP    = 60;
    localparam int THRESH = 30;

    typedef struct {
        logic [7:0]       m;
        logic [7:0]       s;
        logic [ACK_W-1:0] ack;
        string            tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk = 1'b1, bus_mosi = 1'b1, bus_miso = 1'b1;
    logic [IDLE_W-1:0] idle_thresh = IDLE_W'(THRESH);
    logic [7:0] mst_byte, slv_byte;
    logic byte_vld, frame_err;
    logic [ACK_W-1:0] ack_len;

    int total = 0, bad = 0;
    int seen_err = 0, exp_err = 0;
    bit done = 0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    sniff_byte_mon #(.SYNC_STAGES(2), .FILT_LEN(FLEN), .IDLE_W(IDLE_W), .ACK_W(ACK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_mosi(bus_mosi),
        .bus_miso(bus_miso), .idle_thresh(idle_thresh), .mst_byte(mst_byte),
        .slv_byte(slv_byte), .byte_vld(byte_vld), .ack_len(ack_len), .frame_err(frame_err)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] m, input logic [7:0] s, input int n, input int gl);
        for (int i = 0; i < n; i++) begin
            bus_clk = 1'b0; bus_mosi = m[7-i]; bus_miso = s[7-i];
            hold(HALF);
            bus_clk = 1'b1;
            if (i == gl) begin
                hold(2); bus_mosi = ~bus_mosi; hold(FLEN-1); bus_mosi = ~bus_mosi; hold(HALF-2-(FLEN-1));
            end else begin
                hold(HALF);
            end
        end
    endtask

    task automatic ack_phase(input int extra, input int ack);
        bus_miso = 1'b1;
        hold(extra);
        bus_clk = 1'b0; hold(ack);
        bus_clk = 1'b1; hold(GAP);
    endtask

    task automatic send_byte(input logic [7:0] m, input logic [7:0] s, input int extra,
                             input int ack, input int exp_ack, input string tag, input int gl);
        item_t it;
        it.m = m; it.s = s; it.ack = ACK_W'(exp_ack); it.tag = tag;
        exp_q.push_back(it);
        send_bits(m, s, 8, gl);
        ack_phase(extra, ack);
    endtask

    task automatic check_err(input string tag);
        total++;
        if (seen_err != exp_err) begin
            bad++;
            $display("FAIL %s frame_err count actual=%0d expected=%0d", tag, seen_err, exp_err);
        end
    endtask

    // monitor: compare every strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_err) seen_err++;
            if (byte_vld) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R4 unexpected byte_vld actual=%h/%h expected=none", mst_byte, slv_byte);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    total++;
                    if (mst_byte != e.m) begin
                        bad++; $display("FAIL R2 mst_byte actual=%h expected=%h", mst_byte, e.m);
                    end
                    total++;
                    if (slv_byte != e.s) begin
                        bad++; $display("FAIL R3 slv_byte actual=%h expected=%h", slv_byte, e.s);
                    end
                    total++;
                    if (ack_len != e.ack) begin
                        bad++; $display("FAIL %s ack_len actual=%0d expected=%0d", e.tag, ack_len, e.ack);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        hold(5);
        // R1 reset state
        total++;
        if (mst_byte != 0 || slv_byte != 0 || ack_len != 0 || byte_vld || frame_err) begin
            bad++; $display("FAIL R1 reset outputs actual=%h/%h/%0d/%b/%b expected=0", mst_byte, slv_byte, ack_len, byte_vld, frame_err);
        end
        rst_n = 1'b1;
        hold(20);
        total++;
        if (mst_byte != 0 || byte_vld || frame_err) begin
            bad++; $display("FAIL R1 post-reset outputs actual=%h/%b/%b expected=0", mst_byte, byte_vld, frame_err);
        end

        // R2 R3 R4 R5 basic captures
        send_byte(8'hA5, 8'h3C, 60, 20, 20, "R5", -1);
        send_byte(8'h00, 8'hFF, 60, 7, 7, "R5", -1);
        // R4 high interval one cycle above threshold
        send_byte(8'hC6, 8'h1D, THRESH + 1 - HALF, 12, 12, "R4", -1);
        // R5 shortest acknowledge that passes the filter
        send_byte(8'h2B, 8'hD4, 60, FLEN, FLEN, "R5", -1);
        // R6 saturation
        send_byte(8'h81, 8'h7E, 60, 300, 255, "R6", -1);
        // R9 data spike inside a bit
        send_byte(8'h5A, 8'hC3, 60, 10, 10, "R9", 3);
        check_err("R4");

        // R9 clock spike during idle, R10 long idle with nothing pending
        bus_clk = 1'b0; hold(FLEN - 1); bus_clk = 1'b1;
        hold(200);
        check_err("R10");
        total++;
        if (exp_q.size() != 0) begin
            bad++; $display("FAIL R9 pending items actual=%0d expected=0", exp_q.size());
        end

        // R7 five-bit fragment then long idle
        send_bits(8'hF0, 8'h0F, 5, -1);
        exp_err++;
        hold(100);
        check_err("R7");
        send_byte(8'h12, 8'h34, 60, 15, 15, "R7", -1);

        // R8 eight bits then a new byte with no pause
        send_bits(8'hF0, 8'h0F, 8, -1);
        exp_err++;
        send_byte(8'h6E, 8'h91, 60, 9, 9, "R8", -1);
        check_err("R8");

        hold(50);
        total++;
        if (exp_q.size() != 0) begin
            bad++; $display("FAIL R4 missing byte_vld actual=%0d expected=0", exp_q.size());
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule